// File: doc/BRIEF.md
# Synchronous SRAM Read/Write Pipeline

This block is a synthesizable model of a small synchronous static RAM whose address, write data and control inputs are all captured on the rising clock edge. Each word is built from byte lanes that can be written one by one under a byte-write enable, or all together under a global write that overrides the lane strobes. A mode input chooses at run time whether read data leaves the array directly (flow-through) or passes through one more output register first (pipelined).

The shared data bus of a discrete part is split here into an input bus, an output bus and a drive flag, so no tristate pins are needed. The output drivers use dual-cycle-deselect timing: when the chip is deselected after a read, the bus stays driven for one more full cycle before it releases. An output enable and a sleep input act without waiting for the clock. Burst counting is outside this block: the user presents a resolved word address every cycle.

Top module: `sync_sram_pipe`

## Requirements
- R1: A cycle is a chip access only when `cs_a_n` is 0, `cs_b` is 1 and `cs_c_n` is 0 at the rising edge; any other combination is a deselect, and a write attempted during it leaves the array unchanged.
- R2: With `byte_wr_en` high and `global_wr` low, only the lanes whose bit in `lane_stb` is 1 are written (bit i covers `din[9*i+8:9*i]`); with `byte_wr_en` low and `global_wr` low the cycle is a read, whatever `lane_stb` holds.
- R3: With `global_wr` high every lane of the addressed word is written, whatever `byte_wr_en` and `lane_stb` hold.
- R4: With `pipe_mode` 0, read data for an address sampled at edge N is on `dout` with `dout_drive` 1 from just after edge N until edge N+1.
- R5: With `pipe_mode` 1, read data for an address sampled at edge N is on `dout` with `dout_drive` 1 from just after edge N+1 until edge N+2.
- R6: Reads on consecutive edges deliver one word per clock, in the order the addresses were given.
- R7: A deselect sampled at the edge after a read keeps `dout_drive` 1, with the last read word on `dout`, until the next edge; after the second edge following the deselect the bus is released.
- R8: A write never makes `dout_drive` 1 in the cycle it occupies; a read on the edge right after a write to the same address returns the new data.
- R9: `out_en` low forces `dout_drive` and `dout` to 0 at once, without waiting for a clock edge.
- R10: While `sleep` is 1, `dout_drive` and `dout` are 0 at once, commands sampled are ignored (no write, no read, no deselect), and stored words are kept.
- R11: During reset `dout_drive` is 0 and `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline registers |
| cs_a_n | input | 1 | Chip enable, active low |
| cs_b | input | 1 | Chip enable, active high |
| cs_c_n | input | 1 | Chip enable, active low |
| global_wr | input | 1 | Write all lanes |
| byte_wr_en | input | 1 | Qualifies the lane strobes |
| lane_stb | input | LANES | Per-lane write strobes |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write data |
| pipe_mode | input | 1 | 0 flow-through, 1 pipelined read output |
| out_en | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Asynchronous low-power state, active high |
| dout | output | LANES*LANE_W | Read data, 0 while not driven |
| dout_drive | output | 1 | Output bus is being driven |

## Verification
The array is first filled by global writes, then read back in runs of back-to-back addresses that end in one or two deselects, once in each output mode; this separates the one-cycle and two-cycle read latencies and shows whether the drive flag lingers exactly one cycle after a deselect. Byte writes with chosen strobe patterns, strobes without their enable, and global writes with conflicting strobes tell lane masking apart from override. Writes under each single wrong chip enable and under sleep, each followed by a read of the same word, show that nothing was stored, and a write followed at once by a read of its address shows the write order. An output enable pulse placed mid-cycle shows that gating does not wait for the clock.

// File: rtl/sram_pipe_pkg.sv
package sram_pipe_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_DESEL = 2'd3
  } cmd_e;

  // True only when all three enables sit at their select levels.
  function automatic logic chip_on(input logic a_n, input logic b, input logic c_n);
    return !a_n && b && !c_n;
  endfunction

  // Command from select, sleep and whether any lane is being written.
  function automatic cmd_e classify(input logic selected, input logic asleep,
                                    input logic any_lane);
    if (asleep)         return CMD_NOP;
    else if (!selected) return CMD_DESEL;
    else if (any_lane)  return CMD_WRITE;
    else                return CMD_READ;
  endfunction

endpackage

// File: rtl/sram_in_stage.sv
module sram_in_stage
  import sram_pipe_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              cs_a_n,
  input  logic              cs_b,
  input  logic              cs_c_n,
  input  logic              global_wr,
  input  logic              byte_wr_en,
  input  logic [LANES-1:0]  lane_stb,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_en,
  output logic [LANES-1:0]  wr_mask,
  output cmd_e              cmd_q,
  output logic [ADDR_W-1:0] addr_q
);

  function automatic logic [LANES-1:0] lanes_to_write(input logic gw, input logic bw,
                                                      input logic [LANES-1:0] stb);
    if (gw)      return '1;
    else if (bw) return stb;
    else         return '0;
  endfunction

  logic             sel_now;
  logic [LANES-1:0] lane_req;
  cmd_e             cmd_now;

  assign sel_now  = chip_on(cs_a_n, cs_b, cs_c_n);
  assign lane_req = lanes_to_write(global_wr, byte_wr_en, lane_stb);
  assign cmd_now  = classify(sel_now, sleep, |lane_req);
  assign wr_en    = (cmd_now == CMD_WRITE);
  assign wr_mask  = lane_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
    end else begin
      cmd_q  <= cmd_now;
      addr_q <= addr;
    end
  end

  // R1: an access is only registered if the chip was selected and awake.
  p_select_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_READ || cmd_q == CMD_WRITE) |-> $past(sel_now && !sleep));

  // R10: anything sampled under sleep becomes a no-op.
  p_sleep_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sleep) |-> (cmd_q == CMD_NOP));

endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_mask[l])
        cells[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
    end

    assign rd_data[l*LANE_W +: LANE_W] = cells[rd_addr];
  end

endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
  import sram_pipe_pkg::*;
#(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              out_en,
  input  logic              sleep,
  input  cmd_e              cmd_q,
  input  logic [WORD_W-1:0] rd_data,
  output logic [WORD_W-1:0] dout,
  output logic              dout_drive
);

  cmd_e              cmd_prev;
  logic [WORD_W-1:0] data_q;
  logic              prev_read;
  logic              flow_drive;
  logic              raw_drive;
  logic [WORD_W-1:0] data_pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_prev <= CMD_NOP;
      data_q   <= '0;
    end else begin
      cmd_prev <= cmd_q;
      data_q   <= rd_data;
    end
  end

  assign prev_read  = (cmd_prev == CMD_READ);
  // Flow-through: drive on a live read, or hold one cycle when a deselect trails a read.
  assign flow_drive = (cmd_q == CMD_READ) || ((cmd_q == CMD_DESEL) && prev_read);
  assign raw_drive  = pipe_mode ? prev_read : flow_drive;
  assign data_pick  = (!pipe_mode && cmd_q == CMD_READ) ? rd_data : data_q;
  assign dout_drive = raw_drive && out_en && !sleep;
  assign dout       = dout_drive ? data_pick : '0;

  // R7: a deselect right after a read keeps the bus for one more cycle.
  p_dcd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_q) == CMD_READ && cmd_q == CMD_DESEL && out_en && !sleep) |-> dout_drive);

  // R7: two deselects in a row leave the bus released.
  p_dcd_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_q) == CMD_DESEL && cmd_q == CMD_DESEL) |-> !dout_drive);

  // R5: in pipelined mode a read registered one edge ago is on the bus now.
  p_pipe_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && $past(cmd_q) == CMD_READ && out_en && !sleep) |-> dout_drive);

  // R8: a write in flight does not drive the bus in flow-through mode.
  p_write_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && cmd_q == CMD_WRITE) |-> !dout_drive);

  // R10: sleep keeps the bus released.
  p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (!dout_drive && dout == '0));

  // R9: without output enable the data bus reads as zero.
  p_oe_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (dout == '0));

endmodule

// File: rtl/sync_sram_pipe.sv
module sync_sram_pipe
  import sram_pipe_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_a_n,
  input  logic                    cs_b,
  input  logic                    cs_c_n,
  input  logic                    global_wr,
  input  logic                    byte_wr_en,
  input  logic [LANES-1:0]        lane_stb,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic                    pipe_mode,
  input  logic                    out_en,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_drive
);

  localparam int WORD_W = LANES * LANE_W;

  logic              wr_en;
  logic [LANES-1:0]  wr_mask;
  cmd_e              cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] rd_data;

  sram_in_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_in (
    .clk(clk), .rst_n(rst_n), .sleep(sleep),
    .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
    .global_wr(global_wr), .byte_wr_en(byte_wr_en), .lane_stb(lane_stb),
    .addr(addr), .wr_en(wr_en), .wr_mask(wr_mask),
    .cmd_q(cmd_q), .addr_q(addr_q)
  );

  sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_mask(wr_mask), .wr_addr(addr),
    .wr_data(din), .rd_addr(addr_q), .rd_data(rd_data)
  );

  sram_out_stage #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .out_en(out_en),
    .sleep(sleep), .cmd_q(cmd_q), .rd_data(rd_data),
    .dout(dout), .dout_drive(dout_drive)
  );

  // R2: a write never reaches the array with no lane selected.
  p_lane_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_mask != '0));

endmodule

// File: tb/sync_sram_pipe_test.sv
`timescale 1ns/1ps
module sync_sram_pipe_test;

  localparam int T = 20;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cs_a_n = 1, cs_b = 0, cs_c_n = 1;
  logic        global_wr = 0, byte_wr_en = 0;
  logic [3:0]  lane_stb = 0;
  logic [5:0]  addr = 0;
  logic [35:0] din = 0;
  logic        pipe_mode = 0, out_en = 1, sleep = 0;
  logic [35:0] dout;
  logic        dout_drive;

  sync_sram_pipe uut (
    .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
    .global_wr(global_wr), .byte_wr_en(byte_wr_en), .lane_stb(lane_stb),
    .addr(addr), .din(din), .pipe_mode(pipe_mode), .out_en(out_en),
    .sleep(sleep), .dout(dout), .dout_drive(dout_drive)
  );

  always #(T/2) clk = ~clk;

  int    checks = 0, errors = 0;
  bit    done = 0;
  string phase = "R11";

  // Reference model: 0 idle, 1 read, 2 write, 3 deselect.
  logic [35:0] ref_mem [64];
  int          k0 = 0, k1 = 0;
  logic [35:0] v0 = 0, v1 = 0;

  always @(posedge clk) begin
    int          k;
    logic [35:0] v;
    bit          sel;
    v = 0;
    if (!rst_n) k = 0;
    else begin
      sel = !cs_a_n && cs_b && !cs_c_n;
      if (sleep) k = 0;
      else if (!sel) k = 3;
      else if (global_wr || (byte_wr_en && lane_stb != 0)) k = 2;
      else k = 1;
      if (k == 2)
        for (int i = 0; i < 4; i++)
          if (global_wr || lane_stb[i]) ref_mem[addr][i*9 +: 9] = din[i*9 +: 9];
      if (k == 1) v = ref_mem[addr];
    end
    k1 = k0; v1 = v0; k0 = k; v0 = v;
    #5;
    if (!done) begin
      bit          ed;
      logic [35:0] ev;
      if (pipe_mode) begin ed = (k1 == 1); ev = v1; end
      else if (k0 == 1) begin ed = 1; ev = v0; end
      else begin ed = (k0 == 3 && k1 == 1); ev = v1; end
      ed = ed && out_en && !sleep;
      if (!ed) ev = 0;
      checks++;
      if (dout_drive !== ed || dout !== ev) begin
        errors++;
        $display("FAIL %s drive=%0b exp %0b dout=%h exp %h", phase, dout_drive, ed, dout, ev);
      end
    end
  end

  task automatic put(input logic an, input logic b, input logic cn, input logic g,
                     input logic w, input logic [3:0] s, input logic [5:0] a,
                     input logic [35:0] d);
    @(negedge clk);
    cs_a_n = an; cs_b = b; cs_c_n = cn; global_wr = g; byte_wr_en = w;
    lane_stb = s; addr = a; din = d;
  endtask
  task automatic rd(input logic [5:0] a);                   put(0,1,0,0,0,4'h0,a,0); endtask
  task automatic wrg(input logic [5:0] a, input logic [35:0] d); put(0,1,0,1,0,4'h0,a,d); endtask
  task automatic wrb(input logic [5:0] a, input logic [35:0] d, input logic [3:0] s);
    put(0,1,0,0,1,s,a,d);
  endtask
  task automatic des();                                    put(1,1,0,0,0,4'h0,0,0); endtask

  // R9: mid-cycle output enable drop must act without a clock edge.
  task automatic oe_pulse();
    @(posedge clk); #8;
    out_en = 0; #1;
    checks++;
    if (dout_drive !== 1'b0 || dout !== 36'h0) begin
      errors++;
      $display("FAIL R9 drive=%0b exp 0 dout=%h exp 0", dout_drive, dout);
    end
    out_en = 1;
  endtask

  initial begin
    #(T * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    phase = "R3";
    for (int a = 0; a < 64; a++) wrg(6'(a), 36'(a) * 36'h0_0123_4567 + 36'h5);
    phase = "R4"; rd(1); rd(2); rd(3);
    phase = "R7"; des(); des(); des();
    phase = "R6"; rd(4); rd(1); rd(63); rd(0); des(); rd(2); des(); des();
    phase = "R2"; wrb(5, 36'hF_FFFF_FFFF, 4'b0101); rd(5); wrb(6, 36'h0, 4'b1010); rd(6);
    put(0,1,0,0,0,4'b1111,8,36'h0); rd(8); des(); des();
    phase = "R3"; put(0,1,0,1,0,4'h0,7,36'h1_2345_6789); rd(7);
    put(0,1,0,1,1,4'b0001,12,36'hA_BCDE_F012); rd(12); des(); des();
    phase = "R8"; wrg(9, 36'h9_8765_4321); rd(9); wrb(9, 36'h0, 4'b1000); rd(9); des(); des();
    phase = "R1"; put(1,1,0,1,0,0,10,36'h1); put(0,0,0,1,0,0,10,36'h2);
    put(0,1,1,1,0,0,10,36'h3); rd(10); des(); des();
    pipe_mode = 1;
    phase = "R5"; rd(11); rd(12); rd(13); des(); des(); des();
    phase = "R6"; rd(5); rd(6); rd(7); rd(9); des(); des();
    phase = "R8"; wrg(20, 36'h2_2222_2222); rd(20); des(); des();
    phase = "R7"; rd(3); des(); des(); des();
    phase = "R9"; rd(14); oe_pulse(); rd(15); oe_pulse(); des(); des();
    phase = "R10"; sleep = 1; wrg(14, 36'h0); rd(14); rd(15); des();
    @(negedge clk); sleep = 0; rd(14); des(); des();
    pipe_mode = 0; rd(14); des(); des(); des();
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule